// File: doc/BRIEF.md
# Uncore Event Counter Bank

A bank of wide event counters for performance monitoring. Each counter follows one of up to 128 single-cycle event pulses, chosen by an 8-bit event code, and counts only while three conditions hold: the bank-wide run bit is set, the counter's own enable bit is set, and the external traffic filter qualifies the cycle whenever filtering is switched on. One code is reserved to count plain clock cycles.

Software reaches every control and counter through a simple register port. A write takes effect at the clock edge while `reg_we_i` is high. Reads are combinational from `reg_addr_i`. When a counter rolls over from all ones to zero, it latches a status bit. A single interrupt line reports every latched status bit that is not masked. Status bits are cleared through a separate write-one-to-clear register.

Top module: `uncore_evbank`

## Requirements
- R1: There are eight 64-bit counters. Counter n is read and written as one 64-bit word at address 0x1d00 + 8*n.
- R2: Bit 0 of the control word at 0x1c00 is the run bit. While it is 0, no counter changes except by a register write. The control word reads back only bits 1:0.
- R3: Bit n of the enable word at 0x1c14 enables counter n. A counter whose bit is 0 does not count.
- R4: Counters 0-3 take their codes from the 32-bit select word at 0x1c18, and counters 4-7 from the one at 0x1c1c. Counter n uses bits 8*(n mod 4)+7 : 8*(n mod 4). A code below 0x80 counts pulses on event input [code]. A code of 0x80 or more counts nothing.
- R5: Code 0x09 counts every enabled cycle, whatever the event inputs carry.
- R6: Bit 1 of the control word turns on filtering. While it is 1, an increment also needs `filt_qual_i` high.
- R7: When an increment takes a counter from all ones to zero, status bit n is set at the same edge.
- R8: The mask word at 0x0814 has one bit per counter, and a 1 masks that counter. `irq_o` is the OR over n of (status[n] AND NOT mask[n]).
- R9: The status word at 0x0818 is read-only. Writing 1 to bit n at 0x081c clears status bit n, and a 0 leaves it unchanged. If a wrap and a clear hit the same bit in the same cycle, the wrap wins. The clear word reads as 0.
- R10: A register write to a counter takes priority over an increment in the same cycle.
- R11: After reset, the counters, control, enables, select words and status are 0, and the mask is all ones. The identifier word at 0x1cf0 reads the `VERSION` parameter. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register byte address |
| reg_wdata_i | input | 64 | Write data. 32-bit registers use bits 31:0 |
| reg_rdata_o | output | 64 | Combinational read data for `reg_addr_i` |
| evt_i | input | 128 | Event pulses, one bit per event code |
| filt_qual_i | input | 1 | Qualify signal from the traffic filter |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The assertions assume that reset is released away from a clock edge. They also assume that `reg_addr_i`, `reg_we_i`, `evt_i` and `filt_qual_i` settle before each rising edge, and that at most one register write occurs per cycle. The bench meets these conditions by driving every input on the falling edge and holding each write strobe for exactly one cycle. Random event and qualify patterns are applied in those same falling-edge slots. A behavioural model of the bank tracks every counter and status bit each cycle and is compared against register reads and against `irq_o`.

// File: rtl/evbank_pkg.sv
package evbank_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;
  localparam int CODE_W = 8;

  localparam logic [ADDR_W-1:0] A_IMASK = 16'h0814;
  localparam logic [ADDR_W-1:0] A_ISTAT = 16'h0818;
  localparam logic [ADDR_W-1:0] A_ICLR  = 16'h081c;
  localparam logic [ADDR_W-1:0] A_CTRL  = 16'h1c00;
  localparam logic [ADDR_W-1:0] A_CEN   = 16'h1c14;
  localparam logic [ADDR_W-1:0] A_SEL0  = 16'h1c18;
  localparam logic [ADDR_W-1:0] A_VER   = 16'h1cf0;
  localparam logic [ADDR_W-1:0] A_CNT0  = 16'h1d00;

  localparam logic [CODE_W-1:0] CODE_CYCLES = 8'h09;

  typedef struct packed {
    logic filt;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/evbank_ctr.sv
module evbank_ctr
  import evbank_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int NUM_EVT = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gate_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   val_o,
  output logic               wrap_o
);
  localparam int EIDX_W = $clog2(NUM_EVT);

  logic [CNT_W-1:0] val_q, val_d;
  logic             hit, inc, val_en;

  always_comb begin
    if (code_i == CODE_CYCLES) begin
      hit = 1'b1;
    end else if (int'(code_i) < NUM_EVT) begin
      hit = evt_i[code_i[EIDX_W-1:0]];
    end else begin
      hit = 1'b0;
    end
  end

  assign inc    = gate_i & hit;
  assign val_en = wr_i | inc;
  assign wrap_o = inc & ~wr_i & (&val_q);

  always_comb begin
    if (wr_i) begin
      val_d = wdata_i;
    end else begin
      val_d = val_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  assign val_o = val_q;

  // R10
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> val_o == $past(wdata_i));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && !wr_i) |=> $stable(val_o));

  // R4
  bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(code_i) >= NUM_EVT && !wr_i) |=> $stable(val_o));

  // R5
  cycle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && code_i == CODE_CYCLES && !wr_i) |=> val_o == $past(val_o) + CNT_W'(1));

  // R7
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> val_o == '0);
endmodule

// File: rtl/evbank_irq.sv
module evbank_irq #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] wrap_i,
  input  logic [NUM_CNT-1:0] clr_i,
  input  logic [NUM_CNT-1:0] mask_i,
  output logic [NUM_CNT-1:0] status_o,
  output logic               irq_o
);
  logic [NUM_CNT-1:0] stat_q, stat_d;
  logic               stat_en;

  assign stat_en = |(wrap_i | clr_i);

  always_comb begin
    stat_d = (stat_q & ~clr_i) | wrap_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = |(stat_q & ~mask_i);

  // R7
  wrap_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i != '0) |=> ((status_o & $past(wrap_i)) == $past(wrap_i)));

  // R9
  clear_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~wrap_i) != '0) |=> ((status_o & $past(clr_i & ~wrap_i)) == '0));

  // R8
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_o);
endmodule

// File: rtl/evbank_regs.sv
module evbank_regs
  import evbank_pkg::*;
#(
  parameter int          NUM_CNT = 8,
  parameter int          CNT_W   = 64,
  parameter logic [31:0] VERSION = 32'h0000_0201
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_i,
  input  logic [NUM_CNT-1:0]              status_i,
  output ctrl_t                           ctrl_o,
  output logic [NUM_CNT-1:0]              cen_o,
  output logic [NUM_CNT-1:0][CODE_W-1:0]  code_o,
  output logic [NUM_CNT-1:0]              mask_o,
  output logic [NUM_CNT-1:0]              clr_o,
  output logic [NUM_CNT-1:0]              cnt_wr_o,
  output logic [DATA_W-1:0]               rdata_o
);
  localparam int SEL_REGS = (NUM_CNT + 3) / 4;

  ctrl_t                          ctrl_q, ctrl_d;
  logic [NUM_CNT-1:0]             cen_q, cen_d, mask_q, mask_d;
  logic [SEL_REGS-1:0][31:0]      sel_q, sel_d;
  logic                           ctrl_en, cen_en, mask_en;
  logic [SEL_REGS-1:0]            sel_en;

  assign ctrl_en = we_i && (addr_i == A_CTRL);
  assign cen_en  = we_i && (addr_i == A_CEN);
  assign mask_en = we_i && (addr_i == A_IMASK);

  always_comb begin
    ctrl_d = ctrl_t'(wdata_i[1:0]);
    cen_d  = wdata_i[NUM_CNT-1:0];
    mask_d = wdata_i[NUM_CNT-1:0];
    for (int k = 0; k < SEL_REGS; k++) begin
      sel_en[k] = we_i && (addr_i == A_SEL0 + ADDR_W'(4 * k));
      sel_d[k]  = wdata_i[31:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cen_q  <= '0;
      mask_q <= '1;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (cen_en)  cen_q  <= cen_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  for (genvar k = 0; k < SEL_REGS; k++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q[k] <= '0;
      end else if (sel_en[k]) begin
        sel_q[k] <= sel_d[k];
      end
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_dec
    assign code_o[n]   = sel_q[n / 4][8 * (n % 4) +: CODE_W];
    assign cnt_wr_o[n] = we_i && (addr_i == A_CNT0 + ADDR_W'(8 * n));
  end

  assign clr_o  = (we_i && addr_i == A_ICLR) ? wdata_i[NUM_CNT-1:0] : '0;
  assign ctrl_o = ctrl_q;
  assign cen_o  = cen_q;
  assign mask_o = mask_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)  rdata_o = DATA_W'(ctrl_q);
    if (addr_i == A_CEN)   rdata_o = DATA_W'(cen_q);
    if (addr_i == A_IMASK) rdata_o = DATA_W'(mask_q);
    if (addr_i == A_ISTAT) rdata_o = DATA_W'(status_i);
    if (addr_i == A_VER)   rdata_o = DATA_W'(VERSION);
    for (int k = 0; k < SEL_REGS; k++) begin
      if (addr_i == A_SEL0 + ADDR_W'(4 * k)) rdata_o = DATA_W'(sel_q[k]);
    end
    for (int n = 0; n < NUM_CNT; n++) begin
      if (addr_i == A_CNT0 + ADDR_W'(8 * n)) rdata_o = DATA_W'(cnt_i[n]);
    end
  end

  // R11
  ident_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_VER) |-> rdata_o == DATA_W'(VERSION));

  // R9
  status_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_ICLR) |-> rdata_o == '0);
endmodule

// File: rtl/uncore_evbank.sv
module uncore_evbank
  import evbank_pkg::*;
#(
  parameter int          NUM_CNT = 8,
  parameter int          CNT_W   = 64,
  parameter int          NUM_EVT = 128,
  parameter logic [31:0] VERSION = 32'h0000_0201
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [15:0]        reg_addr_i,
  input  logic [63:0]        reg_wdata_i,
  output logic [63:0]        reg_rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               filt_qual_i,
  output logic               irq_o
);
  ctrl_t                          ctrl;
  logic [NUM_CNT-1:0]             cen, mask, clr, cnt_wr, wrap, status, gate;
  logic [NUM_CNT-1:0][CODE_W-1:0] code;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;
  logic                           qual_ok;

  evbank_regs #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .VERSION (VERSION)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .cnt_i    (cnt),
    .status_i (status),
    .ctrl_o   (ctrl),
    .cen_o    (cen),
    .code_o   (code),
    .mask_o   (mask),
    .clr_o    (clr),
    .cnt_wr_o (cnt_wr),
    .rdata_o  (reg_rdata_o)
  );

  assign qual_ok = ~ctrl.filt | filt_qual_i;

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_ctr
    assign gate[n] = ctrl.run & cen[n] & qual_ok;

    evbank_ctr #(
      .CNT_W   (CNT_W),
      .NUM_EVT (NUM_EVT)
    ) i_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .gate_i  (gate[n]),
      .code_i  (code[n]),
      .evt_i   (evt_i),
      .wr_i    (cnt_wr[n]),
      .wdata_i (reg_wdata_i[CNT_W-1:0]),
      .val_o   (cnt[n]),
      .wrap_o  (wrap[n])
    );
  end

  evbank_irq #(
    .NUM_CNT (NUM_CNT)
  ) i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap),
    .clr_i    (clr),
    .mask_i   (mask),
    .status_o (status),
    .irq_o    (irq_o)
  );

  // R6
  filter_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.filt && !filt_qual_i && cnt_wr == '0) |=> $stable(cnt));
endmodule

// File: tb/test_uncore_evbank.sv
module test_uncore_evbank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [15:0]  addr = '0;
  logic [63:0]  wdata = '0;
  logic [63:0]  rdata;
  logic [127:0] evt = '0;
  logic         qual = 1'b0;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [31:0] VER = 32'h0000_0201;

  always #5 clk = ~clk;

  uncore_evbank i_uncore_evbank (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .evt_i       (evt),
    .filt_qual_i (qual),
    .irq_o       (irq)
  );

  // Behavioural reference model
  logic [63:0] m_cnt [8];
  logic [1:0]  m_ctrl;
  logic [7:0]  m_cen, m_mask, m_stat;
  logic [31:0] m_sel [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = '0;
      m_ctrl = '0; m_cen = '0; m_mask = '1; m_stat = '0;
      m_sel[0] = '0; m_sel[1] = '0;
    end else begin
      logic [7:0] wrapv, clrv;
      wrapv = '0;
      clrv = (we && addr == 16'h081c) ? wdata[7:0] : 8'h00;
      for (int i = 0; i < 8; i++) begin
        logic [7:0] c;
        bit hit, inc;
        c = m_sel[i / 4][8 * (i % 4) +: 8];
        if (c == 8'h09) hit = 1;
        else if (c < 8'h80) hit = evt[c];
        else hit = 0;
        inc = m_ctrl[0] && m_cen[i] && (!m_ctrl[1] || qual) && hit;
        if (we && addr == 16'h1d00 + 16'(8 * i)) m_cnt[i] = wdata;
        else if (inc) begin
          if (m_cnt[i] == '1) wrapv[i] = 1'b1;
          m_cnt[i] = m_cnt[i] + 64'd1;
        end
      end
      m_stat = (m_stat & ~clrv) | wrapv;
      if (we) begin
        case (addr)
          16'h1c00: m_ctrl = wdata[1:0];
          16'h1c14: m_cen = wdata[7:0];
          16'h0814: m_mask = wdata[7:0];
          16'h1c18: m_sel[0] = wdata[31:0];
          16'h1c1c: m_sel[1] = wdata[31:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [63:0] mread(logic [15:0] a);
    logic [63:0] r;
    r = '0;
    if (a == 16'h1c00) r = 64'(m_ctrl);
    if (a == 16'h1c14) r = 64'(m_cen);
    if (a == 16'h0814) r = 64'(m_mask);
    if (a == 16'h0818) r = 64'(m_stat);
    if (a == 16'h1cf0) r = 64'(VER);
    if (a == 16'h1c18) r = 64'(m_sel[0]);
    if (a == 16'h1c1c) r = 64'(m_sel[1]);
    for (int i = 0; i < 8; i++)
      if (a == 16'h1d00 + 16'(8 * i)) r = m_cnt[i];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [63:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, string tag);
    logic [63:0] e;
    @(negedge clk);
    we = 1'b0; addr = a;
    #1;
    e = mread(a);
    chk(rdata === e, tag, rdata, e);
  endtask

  task automatic rd_all_cnt(string tag);
    for (int i = 0; i < 8; i++) rd(16'h1d00 + 16'(8 * i), tag);
  endtask

  task automatic run_rand(int cycles, bit rq);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      evt = {$urandom, $urandom, $urandom, $urandom};
      qual = rq ? 1'($urandom) : 1'b1;
    end
    @(negedge clk);
    evt = '0;
  endtask

  // Per-clock interrupt comparison (R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #2;
      chk(irq === |(m_stat & ~m_mask), "R8 irq", 64'(irq), 64'(|(m_stat & ~m_mask)));
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state and identifier
    rd(16'h1c00, "R11 ctrl"); rd(16'h1c14, "R11 cen");
    rd(16'h0814, "R11 mask"); rd(16'h0818, "R11 status");
    rd(16'h1c18, "R11 sel0"); rd(16'h1cf0, "R11 version");
    rd(16'h0a00, "R11 unmapped");
    rd_all_cnt("R11 counters");

    // R4 codes: c0=09 c1=30 c2=31 c3=85 | c4=34 c5=35 c6=7f c7=09
    wr(16'h1c18, 64'h0000_0000_8531_3009);
    wr(16'h1c1c, 64'h0000_0000_097f_3534);
    rd(16'h1c18, "R4 sel0"); rd(16'h1c1c, "R4 sel1");
    wr(16'h1c14, 64'hff);

    // R2: run bit off, nothing counts
    run_rand(20, 0);
    rd_all_cnt("R2 stopped");

    // R1, R4, R5: counting
    wr(16'h1c00, 64'h1);
    run_rand(100, 0);
    rd(16'h1d00, "R5 cycles c0"); rd(16'h1d38, "R5 cycles c7");
    rd(16'h1d18, "R4 invalid code c3");
    rd_all_cnt("R1 counters");

    // R3: only lower four enabled
    wr(16'h1c14, 64'h0f);
    run_rand(50, 0);
    rd_all_cnt("R3 per-counter enable");

    // R6: filter on with random qualify
    wr(16'h1c14, 64'hff);
    wr(16'h1c00, 64'h3);
    run_rand(80, 1);
    rd_all_cnt("R6 filtered");
    qual = 1'b1;

    // R7: wrap of counter 2
    wr(16'h1c00, 64'h0);
    wr(16'h1d10, 64'hffff_ffff_ffff_fffe);
    rd(16'h1d10, "R1 write c2");
    wr(16'h0814, 64'hfb);
    wr(16'h1c14, 64'h04);
    wr(16'h1c00, 64'h1);
    @(negedge clk); evt[8'h31] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); evt = '0;
    rd(16'h1d10, "R7 wrapped c2");
    rd(16'h0818, "R7 status");
    chk(irq === 1'b1, "R8 unmasked irq", 64'(irq), 64'd1);
    wr(16'h0814, 64'hff);
    #3;
    chk(irq === 1'b0, "R8 masked irq", 64'(irq), 64'd0);
    wr(16'h0814, 64'hfb);

    // R9: status read-only, write-one-to-clear
    wr(16'h0818, 64'h0);
    rd(16'h0818, "R9 status ignores write");
    wr(16'h081c, 64'h0);
    rd(16'h0818, "R9 clear zero");
    rd(16'h081c, "R9 clear reads zero");
    wr(16'h081c, 64'h4);
    rd(16'h0818, "R9 clear one");

    // R10: write during counting
    wr(16'h1c14, 64'h01);
    run_rand(5, 0);
    wr(16'h1d00, 64'd100);
    rd(16'h1d00, "R10 write priority");
    rd_all_cnt("R10 counters");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule